// File: doc/BRIEF.md
# Contiguous Transfer Descriptor Coalescer

This block sits in front of a streaming output engine and turns a series of write requests, each a start address and a byte count, into at most two descriptors: the active one, which the engine is draining, and one queued behind it. A request whose address follows on directly from the end of a held region is folded into that region, so a run of adjacent buffers reaches the engine as one long transfer instead of many short ones. A request that cannot be folded in and finds the queue slot taken is held back until the engine has gone idle, and is then started as a fresh transfer.

The engine reports progress through a consume strobe carrying a byte count. The block sums these into a done count for the active region. When the done count reaches the active length, the queued descriptor, if any, is promoted to active in the same clock edge with its done count at zero. Otherwise the block goes idle. A combinational query port tells software-side logic whether a given address is still waiting to be sent. It is waiting if it lies in the unsent tail of the active region or anywhere inside the queued region.

The request port follows valid/ready rules. A transfer happens on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the source holds `req_valid` high and keeps `req_addr` and `req_len` stable. `req_ready` depends on the current request fields and on registered state. It does not depend on the consume strobe.

Top module: `xfer_coalescer`

## Requirements
- R1: A request with nonzero length accepted while idle makes the block busy on the next cycle. The active address and length are set to the request's, the done count is 0 and the queue slot is empty.
- R2: While busy with an empty queue slot, a request whose address equals active address plus active length (modulo 2^32) is accepted, and the active length grows by the request length.
- R3: While busy with a queued descriptor, a request whose address equals queued address plus queued length is accepted, and the queued length grows by the request length.
- R4: While busy with an empty queue slot, a request that does not continue the active region is accepted and stored as the queued descriptor. A queued descriptor exists only while busy.
- R5: While busy with a full queue slot, a request that does not continue the queued region sees `req_ready` low. From then on every nonzero request is refused, even after the queue slot empties, until the block has been idle for a cycle. It is then accepted as a new active transfer.
- R6: While busy, each cycle with `cons_en` high adds `cons_bytes` to `act_done`. `act_done` stays below `act_len`.
- R7: When the done count plus the consumed bytes reaches the active length while a descriptor is queued, the next cycle shows the queued address and length as active, `act_done` at 0 and the queue slot empty.
- R8: When the done count plus the consumed bytes reaches the active length with no queued descriptor, `busy` is low on the next cycle and `act_done` is 0.
- R9: `query_done` is low in the same cycle exactly when `query_addr` satisfies either of two conditions. The first is that `query_addr` minus `act_addr` (modulo 2^32) is at least `act_done` and below `act_len`. The second is that a descriptor is queued and `query_addr` minus `q_addr` is below `q_len`.
- R10: While the block is idle, `query_done` is high for every address.
- R11: A request of length 0 is always accepted at once and changes no state.
- R12: After reset the block is idle, the queue slot is empty, `act_done` is 0 and a nonzero request is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 32 | Request start address |
| req_len | input | 32 | Request length in bytes |
| cons_en | input | 1 | Engine consumed bytes this cycle |
| cons_bytes | input | 32 | Bytes consumed this cycle |
| query_addr | input | 32 | Address to test for completion |
| query_done | output | 1 | High when the queried address is no longer pending |
| busy | output | 1 | An active descriptor exists |
| act_addr | output | 32 | Active region start |
| act_len | output | 32 | Active region length |
| act_done | output | 32 | Bytes of the active region already consumed |
| q_valid | output | 1 | A queued descriptor exists |
| q_addr | output | 32 | Queued region start |
| q_len | output | 32 | Queued region length |

## Verification
`req_ready` and `query_done` are combinational, so they are due in the cycle the request fields, the query address and the registered state present them. The bench compares them 1 ns after driving inputs at the falling edge. Merges, enqueues, done-count updates, promotion and the return to idle all land one rising edge after the cycle that caused them. The bench's behavioural model advances its own state on that same edge from copies of the inputs, and every status output is compared at the following falling edge. Directed sequences cover the stall that outlasts a promotion, and a long randomized phase biases addresses toward region ends, so that merges and drains fall in the same cycle.

// File: rtl/coal_pkg.sv
package coal_pkg;

  // Outcome of evaluating the request port against the held descriptors.
  typedef enum logic [2:0] {
    DEC_ZERO      = 3'd0,  // empty request, accepted with no effect
    DEC_START     = 3'd1,  // idle: becomes the active descriptor
    DEC_MERGE_ACT = 3'd2,  // extends the active region
    DEC_MERGE_Q   = 3'd3,  // extends the queued region
    DEC_ENQUEUE   = 3'd4,  // fills the empty queue slot
    DEC_STALL     = 3'd5   // refused this cycle
  } dec_e;

  localparam int unsigned NUM_REGIONS = 2;

endpackage

// File: rtl/coal_decide.sv
module coal_decide
  import coal_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 32
) (
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          busy,
  input  logic          hold,
  input  logic [AW-1:0] act_addr,
  input  logic [LW-1:0] act_len,
  input  logic          q_valid,
  input  logic [AW-1:0] q_addr,
  input  logic [LW-1:0] q_len,
  output dec_e          dec,
  output logic          ready
);

  logic [AW-1:0] act_end;
  logic [AW-1:0] q_end;
  logic          follows_act;
  logic          follows_q;

  always_comb begin
    act_end     = act_addr + AW'(act_len);
    q_end       = q_addr + AW'(q_len);
    follows_act = (req_addr == act_end);
    follows_q   = (req_addr == q_end);
  end

  // Priority: empty request, idle start, sticky stall, then the merge
  // order (active only while nothing is queued, then queued), then enqueue.
  always_comb begin
    if (req_len == '0)              dec = DEC_ZERO;
    else if (!busy)                 dec = DEC_START;
    else if (hold)                  dec = DEC_STALL;
    else if (!q_valid && follows_act) dec = DEC_MERGE_ACT;
    else if (q_valid && follows_q)  dec = DEC_MERGE_Q;
    else if (!q_valid)              dec = DEC_ENQUEUE;
    else                            dec = DEC_STALL;
    ready = (dec != DEC_STALL);
  end

endmodule

// File: rtl/coal_span.sv
module coal_span #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 32
) (
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] lo,
  input  logic [LW-1:0] len,
  input  logic [AW-1:0] probe,
  output logic          hit
);

  localparam int unsigned CW = (AW > LW) ? AW : LW;

  logic [AW-1:0] off;
  logic [CW-1:0] off_x;
  logic [CW-1:0] lo_x;
  logic [CW-1:0] len_x;

  // Wrap-safe membership: offset from base compared against [lo, len).
  always_comb begin
    off   = probe - base;
    off_x = CW'(off);
    lo_x  = CW'(lo);
    len_x = CW'(len);
    hit   = en && (off_x >= lo_x) && (off_x < len_x);
  end

endmodule

// File: rtl/coal_regs.sv
module coal_regs
  import coal_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  dec_e          dec,
  input  logic          cons_en,
  input  logic [LW-1:0] cons_bytes,
  output logic          busy,
  output logic          hold,
  output logic [AW-1:0] act_addr,
  output logic [LW-1:0] act_len,
  output logic [LW-1:0] act_done,
  output logic          q_valid,
  output logic [AW-1:0] q_addr,
  output logic [LW-1:0] q_len
);

  logic          nx_busy;
  logic          nx_hold;
  logic [AW-1:0] nx_act_addr;
  logic [LW-1:0] nx_act_len;
  logic [LW-1:0] nx_act_done;
  logic          nx_q_valid;
  logic [AW-1:0] nx_q_addr;
  logic [LW-1:0] nx_q_len;
  logic [LW:0]   done_sum;
  logic          drained;

  always_comb begin
    nx_busy     = busy;
    nx_act_addr = act_addr;
    nx_act_len  = act_len;
    nx_act_done = act_done;
    nx_q_valid  = q_valid;
    nx_q_addr   = q_addr;
    nx_q_len    = q_len;

    // Stage 1: apply the request to the descriptors.
    if (req_valid) begin
      unique case (dec)
        DEC_START: begin
          nx_busy     = 1'b1;
          nx_act_addr = req_addr;
          nx_act_len  = req_len;
          nx_act_done = '0;
          nx_q_valid  = 1'b0;
          nx_q_addr   = '0;
          nx_q_len    = '0;
        end
        DEC_MERGE_ACT: nx_act_len = act_len + req_len;
        DEC_MERGE_Q:   nx_q_len   = q_len + req_len;
        DEC_ENQUEUE: begin
          nx_q_valid = 1'b1;
          nx_q_addr  = req_addr;
          nx_q_len   = req_len;
        end
        default: ;
      endcase
    end

    // Stage 2: account engine progress against the updated active length.
    done_sum = {1'b0, act_done} + ((busy && cons_en) ? {1'b0, cons_bytes} : '0);
    drained  = busy && (done_sum >= {1'b0, nx_act_len});
    if (busy) begin
      if (drained) begin
        nx_act_done = '0;
        if (nx_q_valid) begin
          nx_act_addr = nx_q_addr;
          nx_act_len  = nx_q_len;
          nx_q_valid  = 1'b0;
          nx_q_addr   = '0;
          nx_q_len    = '0;
        end else begin
          nx_busy = 1'b0;
        end
      end else begin
        nx_act_done = done_sum[LW-1:0];
      end
    end

    // A refusal stays in force until the engine has gone idle.
    nx_hold = busy ? (hold || (req_valid && dec == DEC_STALL)) : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      hold     <= 1'b0;
      act_addr <= '0;
      act_len  <= '0;
      act_done <= '0;
      q_valid  <= 1'b0;
      q_addr   <= '0;
      q_len    <= '0;
    end else begin
      busy     <= nx_busy;
      hold     <= nx_hold;
      act_addr <= nx_act_addr;
      act_len  <= nx_act_len;
      act_done <= nx_act_done;
      q_valid  <= nx_q_valid;
      q_addr   <= nx_q_addr;
      q_len    <= nx_q_len;
    end
  end

endmodule

// File: rtl/xfer_coalescer.sv
module xfer_coalescer
  import coal_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          cons_en,
  input  logic [LW-1:0] cons_bytes,
  input  logic [AW-1:0] query_addr,
  output logic          query_done,
  output logic          busy,
  output logic [AW-1:0] act_addr,
  output logic [LW-1:0] act_len,
  output logic [LW-1:0] act_done,
  output logic          q_valid,
  output logic [AW-1:0] q_addr,
  output logic [LW-1:0] q_len
);

  dec_e dec;
  logic hold;

  coal_decide #(.AW(AW), .LW(LW)) u_decide (
    .req_addr (req_addr),
    .req_len  (req_len),
    .busy     (busy),
    .hold     (hold),
    .act_addr (act_addr),
    .act_len  (act_len),
    .q_valid  (q_valid),
    .q_addr   (q_addr),
    .q_len    (q_len),
    .dec      (dec),
    .ready    (req_ready)
  );

  coal_regs #(.AW(AW), .LW(LW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .dec        (dec),
    .cons_en    (cons_en),
    .cons_bytes (cons_bytes),
    .busy       (busy),
    .hold       (hold),
    .act_addr   (act_addr),
    .act_len    (act_len),
    .act_done   (act_done),
    .q_valid    (q_valid),
    .q_addr     (q_addr),
    .q_len      (q_len)
  );

  // Region 0 is the unsent tail of the active descriptor, region 1 the
  // whole queued descriptor.
  logic [NUM_REGIONS-1:0]         span_en;
  logic [NUM_REGIONS-1:0][AW-1:0] span_base;
  logic [NUM_REGIONS-1:0][LW-1:0] span_lo;
  logic [NUM_REGIONS-1:0][LW-1:0] span_len;
  logic [NUM_REGIONS-1:0]         span_hit;

  always_comb begin
    span_en[0]   = busy;
    span_base[0] = act_addr;
    span_lo[0]   = act_done;
    span_len[0]  = act_len;
    span_en[1]   = q_valid;
    span_base[1] = q_addr;
    span_lo[1]   = '0;
    span_len[1]  = q_len;
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_span
    coal_span #(.AW(AW), .LW(LW)) u_span (
      .en    (span_en[g]),
      .base  (span_base[g]),
      .lo    (span_lo[g]),
      .len   (span_len[g]),
      .probe (query_addr),
      .hit   (span_hit[g])
    );
  end

  assign query_done = ~|span_hit;

endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [LW-1:0] req_len,
  input logic          cons_en,
  input logic [LW-1:0] cons_bytes,
  input logic          query_done,
  input logic          busy,
  input logic [AW-1:0] act_addr,
  input logic [LW-1:0] act_len,
  input logic [LW-1:0] act_done,
  input logic          q_valid,
  input logic [AW-1:0] q_addr,
  input logic [LW-1:0] q_len
);

  logic          new_req;
  logic [LW:0]   sum_now;
  logic          reach;

  always_comb begin
    new_req = req_valid && (req_len != '0);
    sum_now = {1'b0, act_done} + (cons_en ? {1'b0, cons_bytes} : '0);
    reach   = sum_now >= {1'b0, act_len};
  end

  assert_idle_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    new_req && req_ready && !busy |=>
      busy && act_addr == $past(req_addr) && act_len == $past(req_len) &&
      act_done == '0 && !q_valid);

  assert_stall_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |-> busy && req_len != '0);

  assert_queue_needs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> busy);

  assert_done_below_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> act_done < act_len);

  assert_handover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && q_valid && !new_req && reach |=>
      busy && act_addr == $past(q_addr) && act_len == $past(q_len) &&
      act_done == '0 && !q_valid);

  assert_drain_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !q_valid && !new_req && reach |=> !busy && act_done == '0);

  assert_idle_query_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> query_done);

  assert_zero_len_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_len == '0 |-> req_ready);

  assert_zero_len_nochange_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid && req_len == '0 && !cons_en |=>
      $stable(act_len) && $stable(q_valid) && $stable(q_len) && $stable(act_done));

endmodule

bind xfer_coalescer coal_checker #(.AW(AW), .LW(LW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_len    (req_len),
  .cons_en    (cons_en),
  .cons_bytes (cons_bytes),
  .query_done (query_done),
  .busy       (busy),
  .act_addr   (act_addr),
  .act_len    (act_len),
  .act_done   (act_done),
  .q_valid    (q_valid),
  .q_addr     (q_addr),
  .q_len      (q_len)
);

// File: tb/tb_xfer_coalescer.sv
`timescale 1ns/1ps
module tb_xfer_coalescer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_len = '0;
  logic        cons_en = 1'b0;
  logic [31:0] cons_bytes = '0;
  logic [31:0] query_addr = '0;
  logic        req_ready, query_done, busy, q_valid;
  logic [31:0] act_addr, act_len, act_done, q_addr, q_len;

  always #5 clk = ~clk;

  xfer_coalescer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .cons_en(cons_en),
    .cons_bytes(cons_bytes), .query_addr(query_addr), .query_done(query_done),
    .busy(busy), .act_addr(act_addr), .act_len(act_len), .act_done(act_done),
    .q_valid(q_valid), .q_addr(q_addr), .q_len(q_len)
  );

  // Behavioural reference state.
  bit          m_busy, m_qv, m_hold;
  logic [31:0] m_as, m_al, m_done, m_qs, m_ql;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  function automatic bit m_ready();
    if (req_len == 0) return 1'b1;
    if (!m_busy) return 1'b1;
    if (m_hold) return 1'b0;
    if (!m_qv && req_addr == m_as + m_al) return 1'b1;
    if (m_qv && req_addr == m_qs + m_ql) return 1'b1;
    if (!m_qv) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit m_qdone(logic [31:0] a);
    logic [31:0] off;
    if (!m_busy) return 1'b1;
    off = a - m_as;
    if (off >= m_done && off < m_al) return 1'b0;
    if (m_qv && (a - m_qs) < m_ql) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string tag, string nm, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R5", "req_ready", req_ready, m_ready());
    chk("R9", "query_done", query_done, m_qdone(query_addr));
    chk("R8", "busy", busy, m_busy);
    chk("R7", "act_addr", act_addr, m_as);
    chk("R2", "act_len", act_len, m_al);
    chk("R6", "act_done", act_done, m_done);
    chk("R4", "q_valid", q_valid, m_qv);
    chk("R4", "q_addr", q_addr, m_qs);
    chk("R3", "q_len", q_len, m_ql);
  endtask

  task automatic model_step();
    bit b0, acc;
    longint sum;
    b0  = m_busy;
    acc = req_valid && m_ready();
    if (acc && req_len != 0) begin
      if (!m_busy) begin
        m_busy = 1; m_as = req_addr; m_al = req_len; m_done = 0;
        m_qv = 0; m_qs = 0; m_ql = 0;
      end else if (!m_qv && req_addr == m_as + m_al) m_al = m_al + req_len;
      else if (m_qv && req_addr == m_qs + m_ql) m_ql = m_ql + req_len;
      else begin m_qv = 1; m_qs = req_addr; m_ql = req_len; end
    end
    if (b0) begin
      sum = longint'(m_done) + (cons_en ? longint'(cons_bytes) : 0);
      if (sum >= longint'(m_al)) begin
        m_done = 0;
        if (m_qv) begin
          m_as = m_qs; m_al = m_ql; m_qv = 0; m_qs = 0; m_ql = 0;
        end else m_busy = 0;
      end else m_done = 32'(sum);
      m_hold = m_hold || (req_valid && !acc);
    end else m_hold = 0;
  endtask

  // Inputs were just driven after a falling edge.
  task automatic cyc();
    #1 compare_all();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic drive(bit v, logic [31:0] a, logic [31:0] l,
                       bit ce, logic [31:0] cb, logic [31:0] qa);
    req_valid = v; req_addr = a; req_len = l;
    cons_en = ce; cons_bytes = cb; query_addr = qa;
    cyc();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_busy = 0; m_qv = 0; m_hold = 0;
    m_as = 0; m_al = 0; m_done = 0; m_qs = 0; m_ql = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    req_len = 32'd4; query_addr = 32'h1000;
    #1;
    chk("R12", "busy after reset", busy, 0);
    chk("R12", "q_valid after reset", q_valid, 0);
    chk("R12", "act_done after reset", act_done, 0);
    chk("R12", "ready after reset", req_ready, 1);
    chk("R10", "idle query", query_done, 1);

    // Zero length while idle.
    drive(1, 32'h500, 0, 0, 0, 32'h500);
    chk("R11", "busy after empty request", busy, 0);

    // Start, merge into active, enqueue, merge into queue.
    drive(1, 32'h1000, 16, 0, 0, 32'h1000);
    chk("R1", "busy after start", busy, 1);
    chk("R1", "act_addr after start", act_addr, 32'h1000);
    drive(1, 32'h1010, 8, 1, 4, 32'h1003);
    chk("R2", "act_len after merge", act_len, 24);
    drive(1, 32'h8000, 4, 0, 0, 32'h1004);
    chk("R4", "q_addr after enqueue", q_addr, 32'h8000);
    drive(1, 32'h8004, 4, 0, 0, 32'h8007);
    chk("R3", "q_len after merge", q_len, 8);
    drive(1, 32'h1018, 0, 0, 0, 32'h8007);
    chk("R11", "act_len unchanged by empty request", act_len, 24);
    drive(0, 0, 0, 0, 0, 32'h8008);
    chk("R9", "just past queue", query_done, 1);

    // Stall that outlasts a promotion.
    drive(1, 32'h9000, 4, 0, 0, 32'h1003);
    chk("R9", "consumed active byte", query_done, 1);
    drive(1, 32'h9000, 4, 1, 20, 32'h9000);
    chk("R7", "act_addr after handover", act_addr, 32'h8000);
    chk("R7", "q_valid after handover", q_valid, 0);
    req_valid = 1; cons_en = 0; #1;
    chk("R5", "ready held low after handover", req_ready, 0);
    drive(1, 32'h9000, 4, 1, 8, 32'h8000);
    chk("R8", "idle after drain", busy, 0);
    #1 chk("R5", "ready once idle", req_ready, 1);
    drive(1, 32'h9000, 4, 0, 0, 32'h9000);
    chk("R1", "stalled request started", act_addr, 32'h9000);
    drive(0, 0, 0, 1, 4, 0);
    chk("R8", "short drain", busy, 0);

    // Randomized phase biased toward region ends.
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a, l, qa;
      int sel;
      sel = $urandom % 4;
      case (sel)
        0: a = m_as + m_al;
        1: a = m_qs + m_ql;
        2: a = $urandom;
        default: a = 32'hFFFF_FFF0 + ($urandom % 32);
      endcase
      l  = (($urandom % 6) == 0) ? 0 : ($urandom % 20) + 1;
      qa = (($urandom % 2) == 0) ? m_as + ($urandom % 48) : m_qs + ($urandom % 24);
      drive(($urandom % 3) != 0, a, l, ($urandom % 2) == 1, $urandom % 12, qa);
    end
    finish_run();
  end

endmodule